// File: doc/BRIEF.md
# Three-Sample Group Sum Decimator

This block gathers unsigned ADC codes that arrive on a sample-enable qualified input and reduces them by three: each run of three accepted samples, taken back to back with no overlap, produces one widened sum. The sum appears with a single-cycle valid strobe. Between strobes the sum output keeps its last value, so a consumer may sample it lazily.

Only the first two samples of a group are stored. The third is not stored; it is added to the two held samples as it arrives. A small position machine with three states tracks where the current sample falls in its group:

- `SLOT_FIRST`: takes an accepted sample into the holding register and moves to `SLOT_SECOND`.
- `SLOT_SECOND`: takes an accepted sample into the holding register and moves to `SLOT_THIRD`.
- `SLOT_THIRD`: on an accepted sample, folds the sum and wraps to `SLOT_FIRST`.

In every state a cycle with the enable low leaves the state unchanged. Reset forces `SLOT_FIRST`, so group alignment after power-up is known. No partial sum padded with zeros is ever reported.

Top module: `tri_sum_decim`

## Requirements
- R1: A sample on `smp_data` is accepted only on a rising clock edge where `smp_en` is 1. While `smp_en` is 0, neither the data value nor the cycle has any effect on later sums or on the valid strobe.
- R2: Groups do not overlap. Accepted samples 1 to 3 after reset form the first sum, samples 4 to 6 form the second, and so on.
- R3: After reset, `sum_vld` stays 0 until the third sample has been accepted. No sum built from fewer than three real samples ever appears.
- R4: The group position advances only on accepted samples and returns to the first position after the third sample. The return happens on the same edge that folds the sum.
- R5: `sum_vld` is 1 in the cycle directly after the edge that accepts the third sample of a group, for exactly one cycle. In every other cycle it is 0.
- R6: `sum_out` is 12 bits wide and holds the exact sum of three 10-bit codes without overflow. Three codes of 1023 give 3069.
- R7: Between valid strobes, `sum_out` keeps the value of the most recent sum.
- R8: An asserted `rst_n` (active low, asynchronous) clears `sum_out` to 0, clears `sum_vld` to 0 and returns the position to the first slot. Any partially collected group is discarded.
- R9: Samples are unsigned codes. A code with bit 9 set (for example 512) adds its full positive value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_en | input | 1 | Qualifies `smp_data` as a new sample on this edge |
| smp_data | input | 10 | Unsigned ADC code |
| sum_out | output | 12 | Sum of the last complete group of three samples |
| sum_vld | output | 1 | One-cycle strobe marking a new value on `sum_out` |

## Verification
The grouping is driven with back-to-back enables, with enables spread out by idle cycles that carry junk data, and with a pseudo-random enable pattern. Together these show that only qualified edges count and that the group boundaries never slide. Directed groups of all-maximum codes and of codes with the top bit set separate a correct 12-bit unsigned sum from a truncated or sign-extended one. A reset between the second and third sample of a group shows whether a stale partial group leaks into the next sum. Long idle stretches after a strobe show that the sum holds while the strobe drops.

// File: rtl/tsd_pkg.sv
package tsd_pkg;

    // Position of the next accepted sample inside its group of three.
    typedef enum logic [1:0] {
        SLOT_FIRST  = 2'd0,
        SLOT_SECOND = 2'd1,
        SLOT_THIRD  = 2'd2
    } slot_e;

    // Number of samples stored before the folding sample arrives.
    localparam int HOLD_DEPTH = 2;

    // Extra sum bits needed to add HOLD_DEPTH+1 samples without overflow.
    localparam int GROW_BITS = $clog2(HOLD_DEPTH + 1);

endpackage : tsd_pkg

// File: rtl/tsd_slot_fsm.sv
module tsd_slot_fsm
    import tsd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic smp_en,
    output logic shift_en,
    output logic fold_en
);

    slot_e slot_q;
    slot_e slot_d;

    // Next-state logic: move only on accepted samples.
    always_comb begin
        slot_d = slot_q;
        unique case (slot_q)
            SLOT_FIRST:  if (smp_en) slot_d = SLOT_SECOND;
            SLOT_SECOND: if (smp_en) slot_d = SLOT_THIRD;
            SLOT_THIRD:  if (smp_en) slot_d = SLOT_FIRST;
            default:     slot_d = SLOT_FIRST;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= SLOT_FIRST;
        end else begin
            slot_q <= slot_d;
        end
    end

    // Output decode.
    always_comb begin
        shift_en = 1'b0;
        fold_en  = 1'b0;
        unique case (slot_q)
            SLOT_FIRST:  shift_en = smp_en;
            SLOT_SECOND: shift_en = smp_en;
            SLOT_THIRD:  fold_en  = smp_en;
            default: begin
                shift_en = 1'b0;
                fold_en  = 1'b0;
            end
        endcase
    end

    AST_SLOT_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_en |=> $stable(slot_q)); // R1

    AST_SLOT_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_en && slot_q == SLOT_THIRD) |=> (slot_q == SLOT_FIRST)); // R4

    AST_SLOT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_en && slot_q == SLOT_FIRST) |=> (slot_q == SLOT_SECOND)); // R4

endmodule : tsd_slot_fsm

// File: rtl/tsd_pair_hold.sv
module tsd_pair_hold
    import tsd_pkg::*;
#(
    parameter int SMP_W  = 10,
    parameter int HOLD_N = HOLD_DEPTH
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      shift_en,
    input  logic [SMP_W-1:0]          smp_data,
    output logic [HOLD_N*SMP_W-1:0]   held_flat
);

    logic [SMP_W-1:0] held_q [HOLD_N];

    // Entry 0 is the newest sample; each older entry takes its neighbour.
    generate
        for (genvar g = 0; g < HOLD_N; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    held_q[g] <= '0;
                end else if (shift_en) begin
                    if (g == 0) begin
                        held_q[g] <= smp_data;
                    end else begin
                        held_q[g] <= held_q[(g == 0) ? 0 : g - 1];
                    end
                end
            end
            assign held_flat[g*SMP_W +: SMP_W] = held_q[g];
        end
    endgenerate

    AST_HOLD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (held_flat[SMP_W-1:0] == $past(smp_data))); // R1

    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(held_flat)); // R1

endmodule : tsd_pair_hold

// File: rtl/tsd_fold_sum.sv
module tsd_fold_sum
    import tsd_pkg::*;
#(
    parameter int SMP_W  = 10,
    parameter int HOLD_N = HOLD_DEPTH,
    parameter int SUM_W  = SMP_W + GROW_BITS
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      fold_en,
    input  logic [SMP_W-1:0]          smp_data,
    input  logic [HOLD_N*SMP_W-1:0]   held_flat,
    output logic [SUM_W-1:0]          sum_out,
    output logic                      sum_vld
);

    localparam int PAD_W = SUM_W - SMP_W;

    // Chain of unsigned partial sums, one stage per held sample.
    logic [SUM_W-1:0] part [HOLD_N+1];

    assign part[0] = {{PAD_W{1'b0}}, smp_data};

    generate
        for (genvar g = 0; g < HOLD_N; g++) begin : g_add
            assign part[g+1] = part[g] + {{PAD_W{1'b0}}, held_flat[g*SMP_W +: SMP_W]};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_out <= '0;
            sum_vld <= 1'b0;
        end else begin
            sum_vld <= fold_en;
            if (fold_en) begin
                sum_out <= part[HOLD_N];
            end
        end
    end

    AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sum_vld |=> !sum_vld); // R5

    AST_SUM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !sum_vld |-> $stable(sum_out)); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fold_en |-> (part[HOLD_N] >= part[0])); // R6

endmodule : tsd_fold_sum

// File: rtl/tri_sum_decim.sv
module tri_sum_decim
    import tsd_pkg::*;
#(
    parameter int SMP_W = 10,
    parameter int SUM_W = SMP_W + GROW_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_en,
    input  logic [SMP_W-1:0] smp_data,
    output logic [SUM_W-1:0] sum_out,
    output logic             sum_vld
);

    logic                          shift_en;
    logic                          fold_en;
    logic [HOLD_DEPTH*SMP_W-1:0]   held_flat;

    tsd_slot_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_en   (smp_en),
        .shift_en (shift_en),
        .fold_en  (fold_en)
    );

    tsd_pair_hold #(
        .SMP_W  (SMP_W),
        .HOLD_N (HOLD_DEPTH)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .smp_data  (smp_data),
        .held_flat (held_flat)
    );

    tsd_fold_sum #(
        .SMP_W  (SMP_W),
        .HOLD_N (HOLD_DEPTH),
        .SUM_W  (SUM_W)
    ) u_fold (
        .clk       (clk),
        .rst_n     (rst_n),
        .fold_en   (fold_en),
        .smp_data  (smp_data),
        .held_flat (held_flat),
        .sum_out   (sum_out),
        .sum_vld   (sum_vld)
    );

    AST_VLD_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        sum_vld |-> $past(smp_en)); // R5

    AST_NO_PARTIAL_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_en |=> !sum_vld); // R3

    AST_STEP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({shift_en, fold_en})); // R4

    AST_ACCEPT_ACTS: assert property (@(posedge clk) disable iff (!rst_n)
        smp_en |-> (shift_en || fold_en)); // R1

endmodule : tri_sum_decim

// File: tb/tri_sum_decim_tb_top.sv
`timescale 1ns/1ps
module tri_sum_decim_tb_top;

    logic        clk;
    logic        rst_n;
    logic        smp_en;
    logic [9:0]  smp_data;
    logic [11:0] sum_out;
    logic        sum_vld;

    int tests_run;
    int tests_failed;
    bit done;

    // Reference model state.
    int q[$];
    int exp_sum;
    bit exp_vld;
    int lcg;

    tri_sum_decim dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_en   (smp_en),
        .smp_data (smp_data),
        .sum_out  (sum_out),
        .sum_vld  (sum_vld)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp, input string what);
        tests_run++;
        if (act != exp) begin
            tests_failed++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare(input string tag);
        check(tag, int'(sum_vld), int'(exp_vld), "sum_vld");
        check(tag, int'(sum_out), exp_sum, "sum_out");
    endtask

    // Drive one cycle, update the model on the edge, compare after it.
    task automatic step(input logic en, input logic [9:0] d, input string tag);
        smp_en   = en;
        smp_data = d;
        @(posedge clk);
        exp_vld = 1'b0;
        if (en) begin
            q.push_back(int'(d));
            if (q.size() == 3) begin
                exp_sum = q[0] + q[1] + q[2];
                exp_vld = 1'b1;
                q.delete();
            end
        end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset();
        smp_en   = 1'b0;
        smp_data = 10'h155;
        rst_n    = 1'b0;
        q.delete();
        exp_sum = 0;
        exp_vld = 1'b0;
        @(posedge clk);
        @(negedge clk);
        compare("R8");
        rst_n = 1'b1;
    endtask

    function automatic int next_rand();
        lcg = lcg * 1103515245 + 12345;
        return (lcg >>> 8) & 32'h7fff_ffff;
    endfunction

    initial begin
        tests_run    = 0;
        tests_failed = 0;
        done         = 1'b0;
        lcg          = 7;
        rst_n        = 1'b0;
        smp_en       = 1'b0;
        smp_data     = '0;
        @(negedge clk);
        do_reset();

        // R3: two samples must not give a strobe; the third one does (R5).
        step(1'b1, 10'd5,   "R3");
        step(1'b1, 10'd7,   "R3");
        step(1'b1, 10'd11,  "R5");
        step(1'b0, 10'd999, "R5");

        // R2: back-to-back disjoint groups.
        for (int i = 0; i < 9; i++) step(1'b1, 10'(i * 37 + 3), "R2");

        // R1: idle cycles with junk data between accepted samples.
        step(1'b1, 10'd100, "R1");
        step(1'b0, 10'd1023, "R1");
        step(1'b0, 10'd777, "R1");
        step(1'b1, 10'd200, "R1");
        step(1'b0, 10'd512, "R1");
        step(1'b1, 10'd300, "R1");

        // R7: sum holds through a long idle stretch.
        for (int i = 0; i < 20; i++) step(1'b0, 10'(i * 51), "R7");

        // R6: all-maximum group.
        step(1'b1, 10'd1023, "R6");
        step(1'b1, 10'd1023, "R6");
        step(1'b1, 10'd1023, "R6");
        step(1'b0, 10'd0,    "R6");
        check("R6", int'(sum_out), 3069, "max sum");

        // R9: codes with the top bit set add as unsigned.
        step(1'b1, 10'd512, "R9");
        step(1'b1, 10'd512, "R9");
        step(1'b1, 10'd512, "R9");
        check("R9", int'(sum_out), 1536, "unsigned sum");

        // R8: reset in the middle of a group discards the partial group.
        step(1'b1, 10'd900, "R8");
        step(1'b1, 10'd901, "R8");
        do_reset();
        step(1'b1, 10'd1, "R8");
        step(1'b1, 10'd2, "R8");
        step(1'b1, 10'd3, "R8");
        check("R8", int'(sum_out), 6, "sum after mid-group reset");

        // R4: random enable pattern keeps the group position honest.
        for (int i = 0; i < 600; i++) begin
            int r;
            r = next_rand();
            step(((r & 3) != 0), 10'(r >> 4), "R4");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests_run++;
            tests_failed++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end

endmodule : tri_sum_decim_tb_top